// File: doc/BRIEF.md
# Class-Coded Microprogram Sequencer

This block steps through a microprogram that is split into linear chains. The current microinstruction address has two parts. The high bits are held in a chain register and name the chain. The low bits are held in a component counter and give the position inside that chain. While a word is marked to continue, the counter steps by one and the chain code stays put. At the last word of a chain, the address logic loads both parts at once.

Every chain whose last word does not end the program belongs to a class. A class groups chains that have the same set of successors. The last word of each such chain holds that class code in a separate field of the word. The jump target is computed from this class field and the condition inputs only, so the chain register is not part of the jump decode. Because the class code is read from the word that is already being fetched, no extra cycle is spent. The microoperation trace is the same, cycle for cycle, as that of a sequencer that decodes the chain register directly.

A pulse on `start` begins a run at address zero. The run ends on the word that carries the end bit.

Top module: `cu_class_seq`

## Requirements
- R1: While reset is held and right after it is released, `busy`, `finish`, `mop` and `uaddr` are all zero.
- R2: When `start` is 1 at a clock edge, the next cycle has `busy`=1 and `uaddr`=0. This holds in any state, including in the middle of a run.
- R3: `uaddr` is {chain[2:0], position[1:0]}. The control word bit layout is: [1:0] class, [2] continue, [8:3] microoperations, [9] end. On a word with continue=1, the next address keeps the chain and adds one to the position. The chain lengths for chains 0 to 7 are 2,3,2,3,2,2,2,1.
- R4: On a chain's last word with end=0 and class 00, the next address is 00100 if cond[0]=1. Otherwise it is 01100 if cond[1]=1, and 01000 if not. Chains 0 and 5 hold class 00.
- R5: Class 01 (chains 1, 2 and 4) jumps to 11000 if cond[3]=1, and to 11100 otherwise.
- R6: Class 10 (chain 3) jumps to 10000 if cond[2]=1, and to 10100 otherwise. Class 11 (chain 6) always jumps to 00110.
- R7: The memory places nonzero values (3 at position 0, 2 at position 1) in the class field of continue words. These values have no effect on the next address.
- R8: On the word with end=1 (address 11100), `finish` is 1 in that same cycle. `busy` is 0 from the next cycle on. While idle without `start`, `uaddr` holds and `busy` stays 0.
- R9: While `busy`=1, `mop` equals (uaddr*11+7) mod 64. While idle, `mop` is 0. There are no added cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begins or restarts a run at address 0 |
| cond | input | 4 | Logical conditions x1..x4 on bits 0..3 |
| busy | output | 1 | Fetch is active |
| mop | output | 6 | Microoperations of the current word |
| finish | output | 1 | Current word ends the program |
| uaddr | output | 5 | Current microinstruction address |

## Verification
`mop` and `finish` are combinational reads of the word at the registered address, so they belong to the same cycle as `uaddr`. A new address appears one clock edge after the `start` and `cond` values that select it. The bench drives inputs and then checks outputs on the falling edge. Its model advances one step per rising edge, using the inputs that were held across that edge. The model decodes jumps by chain number, the way the base sequencer does, and is compared on every cycle. Random condition patterns with occasional restarts reach every class and the end word.

// File: rtl/cu_class_pkg.sv
package cu_class_pkg;
  localparam int MOP_W   = 6;
  localparam int COND_W  = 4;
  localparam int CHAIN_W = 3;
  localparam int COMP_W  = 2;
  localparam int CLASS_W = 2;
  localparam int ADDR_W  = CHAIN_W + COMP_W;

  typedef struct packed {
    logic               fin;
    logic [MOP_W-1:0]   mop;
    logic               cont;
    logic [CLASS_W-1:0] cls;
  } uword_t;

  function automatic int chain_len(input int chain);
    case (chain)
      0, 2, 4, 5, 6: chain_len = 2;
      1, 3:          chain_len = 3;
      default:       chain_len = 1;
    endcase
  endfunction

  function automatic logic [CLASS_W-1:0] class_of(input int chain);
    case (chain)
      0, 5:    class_of = CLASS_W'(0);
      3:       class_of = CLASS_W'(2);
      6:       class_of = CLASS_W'(3);
      default: class_of = CLASS_W'(1);
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] mk_addr(input int chain, input int comp);
    mk_addr = {CHAIN_W'(chain), COMP_W'(comp)};
  endfunction

  function automatic uword_t rom_word(input logic [ADDR_W-1:0] a);
    uword_t w;
    int     chain;
    int     comp;
    int     len;
    logic [31:0] v;
    chain  = int'(a[ADDR_W-1:COMP_W]);
    comp   = int'(a[COMP_W-1:0]);
    len    = chain_len(chain);
    v      = 32'(int'(a) * 11 + 7);
    w      = '0;
    w.mop  = v[MOP_W-1:0];
    if (comp < len - 1) begin
      w.cont = 1'b1;
      w.cls  = CLASS_W'(3 - comp);
    end else if (comp == len - 1) begin
      if (chain == (1 << CHAIN_W) - 1) w.fin = 1'b1;
      else                             w.cls = class_of(chain);
    end
    rom_word = w;
  endfunction

  function automatic logic [ADDR_W-1:0] class_target(input logic [CLASS_W-1:0] cls,
                                                     input logic [COND_W-1:0]  x);
    case (cls)
      CLASS_W'(0): class_target = x[0] ? mk_addr(1, 0) : (x[1] ? mk_addr(3, 0) : mk_addr(2, 0));
      CLASS_W'(1): class_target = x[3] ? mk_addr(6, 0) : mk_addr(7, 0);
      CLASS_W'(2): class_target = x[2] ? mk_addr(4, 0) : mk_addr(5, 0);
      default:     class_target = mk_addr(1, 2);
    endcase
  endfunction
endpackage

// File: rtl/cu_cmem.sv
module cu_cmem
  import cu_class_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output uword_t            word
);
  always_comb word = rom_word(addr);
endmodule

// File: rtl/cu_class_decode.sv
module cu_class_decode
  import cu_class_pkg::*;
(
  input  logic [CLASS_W-1:0] cls,
  input  logic [COND_W-1:0]  cond,
  output logic [ADDR_W-1:0]  target
);
  always_comb target = class_target(cls, cond);
endmodule

// File: rtl/cu_seq_reg.sv
module cu_seq_reg
  import cu_class_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cont,
  input  logic              fin,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] uaddr,
  output logic              busy
);
  logic [CHAIN_W-1:0] chain_q;
  logic [COMP_W-1:0]  comp_q;
  logic               busy_q;
  logic               ev_incr, ev_load, ev_stop;

  assign ev_stop = busy_q & ~start & fin;
  assign ev_incr = busy_q & ~start & ~fin & cont;
  assign ev_load = busy_q & ~start & ~fin & ~cont;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      comp_q  <= '0;
      busy_q  <= 1'b0;
    end else if (start) begin
      chain_q <= '0;
      comp_q  <= '0;
      busy_q  <= 1'b1;
    end else if (ev_stop) begin
      busy_q  <= 1'b0;
    end else if (ev_incr) begin
      comp_q  <= comp_q + COMP_W'(1);
    end else if (ev_load) begin
      {chain_q, comp_q} <= target;
    end
  end

  assign uaddr = {chain_q, comp_q};
  assign busy  = busy_q;

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy_q && uaddr == '0));
  assert_incr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_incr |=> (comp_q == $past(comp_q) + COMP_W'(1)) && $stable(chain_q));
  assert_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (!busy_q && $stable(uaddr)));
  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start) |=> (!busy_q && $stable(uaddr)));
endmodule

// File: rtl/cu_class_seq.sv
module cu_class_seq
  import cu_class_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [COND_W-1:0] cond,
  output logic              busy,
  output logic [MOP_W-1:0]  mop,
  output logic              finish,
  output logic [ADDR_W-1:0] uaddr
);
  uword_t              word;
  logic [ADDR_W-1:0]   target;
  logic                jump_now;

  cu_cmem u_cmem (.addr(uaddr), .word(word));

  cu_class_decode u_dec (.cls(word.cls), .cond(cond), .target(target));

  cu_seq_reg u_reg (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cont(word.cont), .fin(word.fin), .target(target),
    .uaddr(uaddr), .busy(busy)
  );

  assign mop      = busy ? word.mop : '0;
  assign finish   = busy & word.fin;
  assign jump_now = busy & ~start & ~word.fin & ~word.cont;

  assert_class0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_now && word.cls == 2'b00 && cond[0]) |=> uaddr == 5'b00100);
  assert_class1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_now && word.cls == 2'b01 && !cond[3]) |=> uaddr == 5'b11100);
  assert_class3_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_now && word.cls == 2'b11) |=> uaddr == 5'b00110);
  assert_ignore_cls_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && word.cont) |=> uaddr[ADDR_W-1:COMP_W] == $past(uaddr[ADDR_W-1:COMP_W]));
  assert_fin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !start) |=> !busy);
endmodule

// File: tb/cu_class_seq_tb.sv
module cu_class_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] cond = '0;
  logic       busy, finish;
  logic [5:0] mop;
  logic [4:0] uaddr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  int    m_chain = 0, m_comp = 0;
  bit    m_busy = 0;
  string m_tag = "R1";

  cu_class_seq u_dut (.clk(clk), .rst_n(rst_n), .start(start), .cond(cond),
                      .busy(busy), .mop(mop), .finish(finish), .uaddr(uaddr));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int len_of(int ch);
    int t[8] = '{2, 3, 2, 3, 2, 2, 2, 1};
    return t[ch];
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    int a;
    a = m_chain * 4 + m_comp;
    chk(m_tag, "uaddr", int'(uaddr), a);
    chk(m_tag, "busy", int'(busy), int'(m_busy));
    chk((m_busy && m_chain == 7) ? "R8" : m_tag, "finish", int'(finish),
        int'(m_busy && m_chain == 7));
    chk("R9", "mop", int'(mop), m_busy ? (a * 11 + 7) % 64 : 0);
  endtask

  // Reference: base sequencer, jumps chosen by chain number
  task automatic model_step(bit st, logic [3:0] x);
    if (st) begin
      m_chain = 0; m_comp = 0; m_busy = 1; m_tag = "R2";
    end else if (!m_busy) begin
      m_tag = "R8";
    end else if (m_chain == 7) begin
      m_busy = 0; m_tag = "R8";
    end else if (m_comp < len_of(m_chain) - 1) begin
      m_comp++; m_tag = "R3 R7";
    end else begin
      m_comp = 0;
      case (m_chain)
        0, 5: begin m_tag = "R4"; m_chain = x[0] ? 1 : (x[1] ? 3 : 2); end
        1, 2, 4: begin m_tag = "R5"; m_chain = x[3] ? 6 : 7; end
        3: begin m_tag = "R6"; m_chain = x[2] ? 4 : 5; end
        default: begin m_tag = "R6"; m_chain = 1; m_comp = 2; end
      endcase
    end
  endtask

  task automatic step(bit st, logic [3:0] x);
    compare();
    start = st;
    cond  = x;
    model_step(st, x);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    m_tag = "R1";
    chk("R1", "busy in reset", int'(busy), 0);
    chk("R1", "mop in reset", int'(mop), 0);
    chk("R1", "uaddr in reset", int'(uaddr), 0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 3; i++) step(1'b0, 4'hF);
    // x1 path: chain 0 -> chain 1 -> class 01 with x4=0 -> end word
    step(1'b1, 4'b0001);
    for (int i = 0; i < 10; i++) step(1'b0, 4'b0001);
    // x2 path: chain 3 -> class 10 -> chain 5 -> class 00 loop
    step(1'b1, 4'b0010);
    for (int i = 0; i < 20; i++) step(1'b0, 4'b0010);
    // x1,x4: reaches chain 6 and the class 11 jump
    step(1'b1, 4'b1001);
    for (int i = 0; i < 20; i++) step(1'b0, 4'b1001);
    // x3 on chain 3 output
    step(1'b1, 4'b0110);
    for (int i = 0; i < 20; i++) step(1'b0, 4'b0110);
    // random conditions, occasional restarts
    for (int i = 0; i < 3000; i++)
      step(($urandom % 40) == 0, 4'($urandom));
    compare();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule